// File: doc/BRIEF.md
# Per-Bank Command Timing Guard

This block sits between a memory controller's command scheduler and a four-bank DDR SDRAM. Each cycle the scheduler presents a command code, a two-bit bank number and an auto-precharge bit. The block answers with one allow flag per command kind. Each flag says whether that kind of command may go to the presented bank in this cycle. A command is taken into the block's state only when its own flag is high in the cycle it is presented. An illegal command changes nothing.

The block keeps track of which banks hold an open row. For each bank it counts down to the earliest legal activate, column access and precharge. It also keeps shared counters for the spacing between banks: activate to activate, column to column, write to read turnaround, read to write turnaround and burst occupancy. Every gap is a cycle-count parameter. The write-recovery-plus-precharge term after a write with auto-precharge never drops below three cycles. All counters stop at zero, and reset clears them.

Top module: `bank_cmd_guard`

## Requirements
- R1: Command codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4, PALL=5, BST=6. After reset no bank is open, and allow_act, allow_pre and allow_pall are 1 while allow_rd, allow_wr and allow_bst are 0.
- R2: An accepted ACT opens its bank. READ and WRITE to that bank are allowed no earlier than T_RCD cycles after the ACT.
- R3: An ACT to any bank is allowed no earlier than T_RRD cycles after an accepted ACT.
- R4: A new ACT to the same bank needs T_RC cycles after its previous ACT and T_RP cycles after the PRE or PALL that closed it, whichever ends later.
- R5: Any two accepted column commands (READ or WRITE, any banks) are at least T_CCD cycles apart.
- R6: A READ is allowed no earlier than WL + BL/2 + T_WTR cycles after an accepted WRITE.
- R7: A WRITE is allowed no earlier than CL + BL/2 cycles after an accepted READ. BST is allowed only in the BL/2 - 1 cycles that follow a column command. After a BST, a WRITE is allowed CL cycles later unless the read's own wait ends sooner, and BST is no longer allowed.
- R8: A PRE to a bank written without auto-precharge is allowed no earlier than WL + BL/2 + T_WR cycles after the WRITE.
- R9: A WRITE with auto-precharge closes its bank at once. The next ACT to that bank is allowed WL + BL/2 + max(3, T_WR + T_RP) cycles after the WRITE.
- R10: A READ with auto-precharge closes its bank at once. The next ACT to that bank is allowed BL/2 + T_RP cycles after the READ.
- R11: READ or WRITE to a closed bank and ACT to an open bank have their allow flag low. When presented anyway they leave bank_open and every timer unchanged.
- R12: PALL closes every open bank. It is allowed only when no open bank is still waiting out its write-to-precharge gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | Command code presented this cycle (R1 encoding) |
| ba | input | 2 | Bank the command and the allow flags refer to |
| ap | input | 1 | Auto-precharge request on READ or WRITE |
| allow_act | output | 1 | ACT to bank ba is legal now |
| allow_rd | output | 1 | READ to bank ba is legal now |
| allow_wr | output | 1 | WRITE to bank ba is legal now |
| allow_pre | output | 1 | PRE to bank ba is legal now |
| allow_pall | output | 1 | PALL is legal now |
| allow_bst | output | 1 | BST is legal now |
| bank_open | output | 4 | One bit per bank, set while a row is open |

## Verification
Each gap is measured as a count of cycles. One command is issued, and the bench then polls a single allow flag until it rises. Activate-to-column, activate-to-activate and precharge-to-activate are swept over all four banks. This separates per-bank timers from shared ones and shows that a bank index cannot alias another bank. Single runs cover each turnaround, the auto-precharge closes and the burst stop. Each run is built so that the gap under test is the longest one in play, so a wrong term shows up as a wrong count. Illegal commands are followed at once by a command whose flag would have dropped had the illegal one been taken.

// File: rtl/bank_cmd_guard.sv
`timescale 1ns/1ps
module bank_cmd_guard #(
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_RC  = 10,
  parameter int T_RP  = 3,
  parameter int T_CCD = 2,
  parameter int T_WR  = 3,
  parameter int T_WTR = 2,
  parameter int CL    = 3,
  parameter int WL    = 1,
  parameter int BL    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  input  logic [1:0] ba,
  input  logic       ap,
  output logic       allow_act,
  output logic       allow_rd,
  output logic       allow_wr,
  output logic       allow_pre,
  output logic       allow_pall,
  output logic       allow_bst,
  output logic [3:0] bank_open
);

  localparam int NB   = 4;
  localparam int BL2  = BL / 2;
  localparam int TDAL = (T_WR + T_RP < 3) ? 3 : T_WR + T_RP;
  localparam int TWPD = WL + BL2 + T_WR;
  localparam int MAXV = T_RC + T_RP + WL + BL2 + TDAL + CL + TWPD + T_WTR + T_CCD + T_RRD + T_RCD;
  localparam int CW   = $clog2(MAXV + 1);

  localparam logic [CW-1:0] L_RCD  = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RRD  = CW'(T_RRD - 1);
  localparam logic [CW-1:0] L_RC   = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_CCD  = CW'(T_CCD - 1);
  localparam logic [CW-1:0] L_WTR  = CW'(WL + BL2 + T_WTR - 1);
  localparam logic [CW-1:0] L_RTW  = CW'(CL + BL2 - 1);
  localparam logic [CW-1:0] L_BSTZ = CW'(CL - 1);
  localparam logic [CW-1:0] L_WPD  = CW'(TWPD - 1);
  localparam logic [CW-1:0] L_RAP  = CW'(BL2 + T_RP - 1);
  localparam logic [CW-1:0] L_WAP  = CW'(WL + BL2 + TDAL - 1);
  localparam logic [CW-1:0] L_BUSY = CW'(BL2 - 1);

  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_PALL = 3'd5, C_BST = 3'd6;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CW-1:0] rcd_q [NB];
  logic [CW-1:0] act_q [NB];
  logic [CW-1:0] pre_q [NB];
  logic [CW-1:0] rcd_d [NB];
  logic [CW-1:0] act_d [NB];
  logic [CW-1:0] pre_d [NB];
  logic [NB-1:0] open_q, open_d;
  logic [CW-1:0] rrd_q, ccd_q, wtr_q, rtw_q, busy_q;
  logic [CW-1:0] rrd_d, ccd_d, wtr_d, rtw_d, busy_d;
  logic          col_ok;

  assign col_ok    = open_q[ba] && rcd_q[ba] == '0 && ccd_q == '0;
  assign allow_act = !open_q[ba] && act_q[ba] == '0 && rrd_q == '0;
  assign allow_rd  = col_ok && wtr_q == '0;
  assign allow_wr  = col_ok && rtw_q == '0;
  assign allow_pre = pre_q[ba] == '0;
  assign allow_bst = busy_q != '0;
  assign bank_open = open_q;

  always_comb begin
    allow_pall = 1'b1;
    for (int b = 0; b < NB; b++)
      if (open_q[b] && pre_q[b] != '0) allow_pall = 1'b0;
  end

  logic acc_act, acc_rd, acc_wr, acc_pre, acc_pall, acc_bst, acc_col;
  assign acc_act  = cmd == C_ACT  && allow_act;
  assign acc_rd   = cmd == C_RD   && allow_rd;
  assign acc_wr   = cmd == C_WR   && allow_wr;
  assign acc_pre  = cmd == C_PRE  && allow_pre;
  assign acc_pall = cmd == C_PALL && allow_pall;
  assign acc_bst  = cmd == C_BST  && allow_bst;
  assign acc_col  = acc_rd || acc_wr;

  always_comb begin
    open_d = open_q;
    for (int b = 0; b < NB; b++) begin
      rcd_d[b] = dec(rcd_q[b]);
      act_d[b] = dec(act_q[b]);
      pre_d[b] = dec(pre_q[b]);
      if (acc_act && ba == 2'(b)) begin
        open_d[b] = 1'b1;
        rcd_d[b]  = L_RCD;
        act_d[b]  = L_RC;
      end
      if (acc_col && ap && ba == 2'(b)) begin
        open_d[b] = 1'b0;
        act_d[b]  = mx(act_d[b], acc_rd ? L_RAP : L_WAP);
      end
      if (acc_wr && !ap && ba == 2'(b))
        pre_d[b] = L_WPD;
      if (((acc_pre && ba == 2'(b)) || acc_pall) && open_q[b]) begin
        open_d[b] = 1'b0;
        act_d[b]  = mx(act_d[b], L_RP);
      end
    end
    rrd_d  = acc_act ? L_RRD : dec(rrd_q);
    ccd_d  = acc_col ? L_CCD : dec(ccd_q);
    wtr_d  = acc_wr  ? L_WTR : dec(wtr_q);
    busy_d = acc_col ? L_BUSY : (acc_bst ? '0 : dec(busy_q));
    if (acc_rd)       rtw_d = L_RTW;
    else if (acc_bst) rtw_d = (dec(rtw_q) < L_BSTZ) ? dec(rtw_q) : L_BSTZ;
    else              rtw_d = dec(rtw_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      rrd_q  <= '0;
      ccd_q  <= '0;
      wtr_q  <= '0;
      rtw_q  <= '0;
      busy_q <= '0;
      for (int b = 0; b < NB; b++) begin
        rcd_q[b] <= '0;
        act_q[b] <= '0;
        pre_q[b] <= '0;
      end
    end else begin
      open_q <= open_d;
      rrd_q  <= rrd_d;
      ccd_q  <= ccd_d;
      wtr_q  <= wtr_d;
      rtw_q  <= rtw_d;
      busy_q <= busy_d;
      for (int b = 0; b < NB; b++) begin
        rcd_q[b] <= rcd_d[b];
        act_q[b] <= act_d[b];
        pre_q[b] <= pre_d[b];
      end
    end
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_act |=> bank_open[$past(ba)]); // R2
  AST_RCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_act && T_RCD > 1) |=> (ba != $past(ba) || !allow_rd)); // R2
  AST_RRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_act && T_RRD > 1) |=> !allow_act); // R3
  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_col && ap) |=> !bank_open[$past(ba)]); // R9
  AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_RD && !allow_rd) || (cmd == C_ACT && !allow_act)) |=> $stable(bank_open)); // R11
  AST_PALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pall |=> bank_open == '0); // R12
  AST_BST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bst |=> !allow_bst); // R7

endmodule

// File: tb/bank_cmd_guard_test.sv
`timescale 1ns/1ps
module bank_cmd_guard_test;
  localparam int T_RCD = 3, T_RRD = 2, T_RC = 10, T_RP = 3, T_CCD = 2;
  localparam int T_WR = 3, T_WTR = 2, CL = 3, WL = 1, BL = 4;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PALL = 5, BST = 6;

  logic clk = 0, rst_n = 0, ap = 0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] ba = 2'd0;
  logic allow_act, allow_rd, allow_wr, allow_pre, allow_pall, allow_bst;
  logic [3:0] bank_open;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_cmd_guard #(.T_RCD(T_RCD), .T_RRD(T_RRD), .T_RC(T_RC), .T_RP(T_RP), .T_CCD(T_CCD),
    .T_WR(T_WR), .T_WTR(T_WTR), .CL(CL), .WL(WL), .BL(BL)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .ap(ap),
    .allow_act(allow_act), .allow_rd(allow_rd), .allow_wr(allow_wr), .allow_pre(allow_pre),
    .allow_pall(allow_pall), .allow_bst(allow_bst), .bank_open(bank_open));

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic issue(int c, int b, bit a);
    @(negedge clk);
    cmd = 3'(c); ba = 2'(b); ap = a;
    @(posedge clk); #1;
    cmd = 3'd0; ap = 0;
  endtask

  function automatic logic flag(int s);
    case (s)
      ACT: return allow_act;
      RD: return allow_rd;
      WR: return allow_wr;
      PRE: return allow_pre;
      PALL: return allow_pall;
      default: return allow_bst;
    endcase
  endfunction

  task automatic measure(int s, int b, output int gap);
    gap = 1;
    forever begin
      @(negedge clk); ba = 2'(b); #1;
      if (flag(s)) break;
      gap++;
      if (gap > 64) break;
    end
  endtask

  task automatic settle();
    repeat (30) @(posedge clk);
    issue(PALL, 0, 0);
    repeat (30) @(posedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 open", bank_open, 0);
    chk("R1 act", allow_act, 1);
    chk("R1 rd", allow_rd, 0);
    chk("R1 wr", allow_wr, 0);
    chk("R1 pre", allow_pre, 1);
    chk("R1 pall", allow_pall, 1);
    chk("R1 bst", allow_bst, 0);

    for (int b = 0; b < 4; b++) begin
      settle();
      issue(ACT, b, 0);
      chk("R2 open", bank_open, 1 << b);
      measure(RD, b, g); chk("R2 rcd", g, T_RCD);
      settle();
      issue(ACT, b, 0);
      measure(ACT, (b + 1) % 4, g); chk("R3 rrd", g, T_RRD);
      settle();
      issue(ACT, b, 0);
      repeat (20) @(posedge clk);
      issue(PRE, b, 0);
      measure(ACT, b, g); chk("R4 rp", g, T_RP);
    end

    settle();
    issue(ACT, 0, 0);
    issue(PRE, 0, 0);
    measure(ACT, 0, g); chk("R4 rc", g, imax(T_RC - 1, T_RP));

    settle();
    issue(ACT, 0, 0); repeat (10) @(posedge clk);
    issue(RD, 0, 0);
    measure(RD, 0, g); chk("R5 ccd", g, T_CCD);

    settle();
    issue(ACT, 0, 0); repeat (10) @(posedge clk);
    issue(WR, 0, 0);
    measure(RD, 0, g); chk("R6 wtr", g, imax(T_CCD, WL + BL / 2 + T_WTR));

    settle();
    issue(ACT, 0, 0); repeat (10) @(posedge clk);
    issue(RD, 0, 0);
    measure(WR, 0, g); chk("R7 rtw", g, imax(T_CCD, CL + BL / 2));

    settle();
    issue(ACT, 0, 0); repeat (10) @(posedge clk);
    issue(RD, 0, 0);
    #1 chk("R7 bst in burst", allow_bst, 1);
    issue(BST, 0, 0);
    #1 chk("R7 bst after stop", allow_bst, 0);
    measure(WR, 0, g); chk("R7 bstz", g, CL);

    settle();
    issue(ACT, 0, 0); repeat (10) @(posedge clk);
    issue(WR, 0, 0);
    #1 chk("R12 pall held", allow_pall, 0);
    measure(PRE, 0, g); chk("R8 wpd", g, WL + BL / 2 + T_WR);

    settle();
    issue(ACT, 0, 0); repeat (20) @(posedge clk);
    issue(WR, 0, 1);
    chk("R9 closed", bank_open, 0);
    measure(ACT, 0, g); chk("R9 dal", g, WL + BL / 2 + imax(3, T_WR + T_RP));

    settle();
    issue(ACT, 0, 0); repeat (20) @(posedge clk);
    issue(RD, 0, 1);
    chk("R10 closed", bank_open, 0);
    measure(ACT, 0, g); chk("R10 rap", g, BL / 2 + T_RP);

    settle();
    issue(ACT, 0, 0); repeat (10) @(posedge clk);
    @(negedge clk); ba = 2'd1; #1 chk("R11 rd closed flag", allow_rd, 0);
    issue(RD, 1, 0);
    @(negedge clk); ba = 2'd0; #1;
    chk("R11 rd ccd untouched", allow_rd, 1);
    chk("R11 wr rtw untouched", allow_wr, 1);
    chk("R11 open kept", bank_open, 1);
    @(negedge clk); ba = 2'd0; #1 chk("R11 act open flag", allow_act, 0);
    issue(ACT, 0, 0);
    @(negedge clk); ba = 2'd2; #1 chk("R11 rrd untouched", allow_act, 1);

    settle();
    issue(ACT, 0, 0); repeat (3) @(posedge clk);
    issue(ACT, 1, 0); repeat (12) @(posedge clk);
    chk("R12 both open", bank_open, 3);
    issue(PALL, 0, 0);
    chk("R12 closed", bank_open, 0);
    measure(ACT, 1, g); chk("R12 rp", g, T_RP);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule